// File: doc/BRIEF.md
# AHCI Port Software-Reset Sequencer

This block is the per-port controller that follows the two-step software reset which host software performs with register host-to-device FISes. A decoder upstream presents each such FIS as a one-cycle event carrying its device-control byte, the command slot that carried it, and the clear-busy option from that slot's command header. The block decides whether the port moves between its running and resetting states. It owns the command-issue and SActive bitmaps, the task-file data and signature registers, and the busy-slot tracker.

When host software sets the SRST bit, the port enters its resetting state. No device-to-host FIS answers this step. The issued slot is therefore released only when its command header asks for a clear on acceptance. When SRST is then cleared, the port loads its reset values and requests one initial device-to-host FIS. A COMRESET event has the same effect from either state. The initial FIS leaves the command-issue bitmap alone. Its arrival rebuilds the signature from the task-file bytes it carries and marks the initial FIS as delivered.

Every output is a register. A result appears one clock after the event that causes it. The asynchronous reset is released through a two-stage synchroniser.

Top module: `ahci_srst_seq`

## Requirements
- R1: While running, an accepted FIS with bit 2 of its device-control byte (SRST) set moves the port to the resetting state (`port_in_reset_o` = 1) on the next clock.
- R2: On that SRST-set FIS, if `h2d_clr_busy_i` is 1, the bit of `h2d_slot_i` in `ci_o` is cleared on the next clock, and `clr_pulse_o` is high for exactly one cycle with `clr_slot_o` equal to the slot. If `h2d_clr_busy_i` is 0, `ci_o` is unchanged and no pulse is produced.
- R3: An SRST-set FIS while resetting, and an SRST-clear FIS while running, leave the state unchanged. A clear-busy request on a FIS received while resetting changes nothing in `ci_o`.
- R4: While resetting, an SRST-clear FIS performs a port reset on the next clock. The state becomes running, `ci_o` = 0, `sact_o` = 0, `tfd_o` = 0x007F, `sig_o` = 0xFFFFFFFF, `busy_valid_o` = 0 and `init_d2h_req_o` = 1.
- R5: `comreset_i` performs the same port reset from either state. It takes priority over any FIS or acknowledge in the same cycle, so no clear pulse results.
- R6: `init_d2h_req_o` stays high after a port reset until `d2h_ack_i` is accepted, and then falls. Accepting the initial FIS never changes `ci_o`. An acknowledge that arrives in the same cycle as a port reset is discarded.
- R7: An accepted acknowledge loads `sig_o` = {hcyl, lcyl, sector, nsect} (hcyl in bits 31:24, lcyl in 23:16) and `tfd_o` = {error, status}. An acknowledge while `init_d2h_req_o` is 0 changes nothing.
- R8: `issue_valid_i` ORs `issue_ci_i` into `ci_o` and `issue_sact_i` into `sact_o` on the next clock. A same-cycle clear of a slot wins over its issue.
- R9: Any FIS accepted while running loads the busy tracker with its slot (`busy_valid_o` = 1). A clear of that slot under R2 in the same cycle leaves the tracker empty.
- R10: While `rst_n_i` is low, all outputs hold the port-reset values of R4, with the state running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| comreset_i | input | 1 | Link-level reset event, one cycle |
| h2d_valid_i | input | 1 | Decoded register host-to-device FIS present |
| h2d_devctl_i | input | 8 | Device-control byte of the FIS; bit 2 is SRST |
| h2d_slot_i | input | 5 | Command slot that carried the FIS |
| h2d_clr_busy_i | input | 1 | Command-header option: clear busy on acceptance |
| issue_valid_i | input | 1 | Software issues commands this cycle |
| issue_ci_i | input | 32 | Slots to set in the command-issue bitmap |
| issue_sact_i | input | 32 | Slots to set in SActive |
| d2h_ack_i | input | 1 | Initial device-to-host FIS accepted |
| d2h_status_i | input | 8 | Status byte of that FIS |
| d2h_error_i | input | 8 | Error byte of that FIS |
| d2h_nsect_i | input | 8 | Sector-count byte of that FIS |
| d2h_sector_i | input | 8 | Sector-number byte of that FIS |
| d2h_lcyl_i | input | 8 | Low-cylinder byte of that FIS |
| d2h_hcyl_i | input | 8 | High-cylinder byte of that FIS |
| port_in_reset_o | output | 1 | 1 while in the resetting state |
| ci_o | output | 32 | Command-issue bitmap |
| sact_o | output | 32 | SActive bitmap |
| tfd_o | output | 16 | Task-file data {error, status} |
| sig_o | output | 32 | Device signature |
| busy_valid_o | output | 1 | Busy tracker holds a slot |
| busy_slot_o | output | 5 | Slot held by the busy tracker |
| init_d2h_req_o | output | 1 | Initial device-to-host FIS requested |
| clr_pulse_o | output | 1 | One-cycle pulse: a command-issue bit was cleared |
| clr_slot_o | output | 5 | Index of the cleared slot |

## Verification
The bench runs the full reset sequence once for every slot, with the clear-busy option both off and on. A design that decodes the slot mask wrongly would clear a neighbouring bit or several bits. A design that ignores the option would either always or never release the slot. The sequence also sends a repeated SRST-set FIS while resetting and an SRST-clear FIS while running. A design that clears on these would drop an issued command, and one that toggles state on them would reset the port spuriously. The bench also drives three same-cycle collisions: COMRESET against an SRST-set FIS, an acknowledge against a port reset, and an acknowledge that arrives without a request. A wrong priority there would leave a stale pulse, a lost request or an overwritten signature.

// File: rtl/ahci_srst_pkg.sv
package ahci_srst_pkg;

  localparam int unsigned DEVCTL_SRST_BIT = 2;
  localparam logic [15:0] TFD_RESET_VAL   = 16'h007F;
  localparam logic [31:0] SIG_RESET_VAL   = 32'hFFFF_FFFF;

  typedef enum logic {
    PS_RUN   = 1'b0,
    PS_RESET = 1'b1
  } port_state_e;

endpackage

// File: rtl/ahci_rst_sync.sv
module ahci_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_sync_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/ahci_srst_fsm.sv
module ahci_srst_fsm
  import ahci_srst_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_n_i,
  input  logic        fis_valid_i,
  input  logic        srst_i,
  input  logic        comreset_i,
  output port_state_e state_o,
  output logic        port_reset_o,
  output logic        srst_enter_o
);

  port_state_e state_q;
  port_state_e state_d;
  logic        state_en;

  always_comb begin
    port_reset_o = comreset_i | (fis_valid_i & (state_q == PS_RESET) & ~srst_i);
    srst_enter_o = ~comreset_i & fis_valid_i & (state_q == PS_RUN) & srst_i;
    state_en     = port_reset_o | srst_enter_o;
    state_d      = state_q;
    if (port_reset_o) begin
      state_d = PS_RUN;
    end else if (srst_enter_o) begin
      state_d = PS_RESET;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= PS_RUN;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

  AST_SRST_ENTERS_RESET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (fis_valid_i && srst_i && !comreset_i && state_q == PS_RUN) |=> (state_q == PS_RESET)); // R1

  AST_RESET_HOLDS_ON_SRST: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (fis_valid_i && srst_i && !comreset_i && state_q == PS_RESET) |=> (state_q == PS_RESET)); // R3

  AST_RUN_HOLDS_ON_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (fis_valid_i && !srst_i && state_q == PS_RUN) |=> (state_q == PS_RUN)); // R3

  AST_COMRESET_TO_RUN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    comreset_i |=> (state_q == PS_RUN)); // R5

endmodule

// File: rtl/ahci_ci_bitmap.sv
module ahci_ci_bitmap #(
  parameter int unsigned NUM_SLOTS = 32,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_n_i,
  input  logic                 port_reset_i,
  input  logic                 issue_valid_i,
  input  logic [NUM_SLOTS-1:0] issue_ci_i,
  input  logic [NUM_SLOTS-1:0] issue_sact_i,
  input  logic                 clr_req_i,
  input  logic [SLOT_W-1:0]    clr_slot_i,
  output logic [NUM_SLOTS-1:0] ci_o,
  output logic [NUM_SLOTS-1:0] sact_o,
  output logic                 clr_pulse_o,
  output logic [SLOT_W-1:0]    clr_slot_o
);

  logic [NUM_SLOTS-1:0] clr_mask;
  logic [NUM_SLOTS-1:0] ci_q, ci_d, sact_q, sact_d;
  logic                 ci_en, sact_en, pulse_q, pulse_d;
  logic [SLOT_W-1:0]    pslot_q;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_clr
    assign clr_mask[g] = clr_req_i && (clr_slot_i == SLOT_W'(g));
  end

  always_comb begin
    ci_en   = port_reset_i | issue_valid_i | clr_req_i;
    sact_en = port_reset_i | issue_valid_i;
    pulse_d = clr_req_i & ~port_reset_i;
    if (port_reset_i) begin
      ci_d   = '0;
      sact_d = '0;
    end else begin
      ci_d   = (issue_valid_i ? (ci_q | issue_ci_i) : ci_q) & ~clr_mask;
      sact_d = issue_valid_i ? (sact_q | issue_sact_i) : sact_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ci_q    <= '0;
      sact_q  <= '0;
      pulse_q <= 1'b0;
      pslot_q <= '0;
    end else begin
      if (ci_en)     ci_q    <= ci_d;
      if (sact_en)   sact_q  <= sact_d;
      pulse_q <= pulse_d;
      if (clr_req_i) pslot_q <= clr_slot_i;
    end
  end

  assign ci_o        = ci_q;
  assign sact_o      = sact_q;
  assign clr_pulse_o = pulse_q;
  assign clr_slot_o  = pslot_q;

  AST_CLR_MASK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $onehot0(clr_mask)); // R2

  AST_CLEARED_BIT_LOW: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (clr_req_i && !port_reset_i) |=> !ci_q[$past(clr_slot_i)]); // R2

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (pulse_q && !clr_req_i) |=> !pulse_q); // R2

  AST_BITMAPS_RESET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    port_reset_i |=> (ci_q == '0 && sact_q == '0)); // R4

endmodule

// File: rtl/ahci_port_regs.sv
module ahci_port_regs
  import ahci_srst_pkg::*;
#(
  parameter int unsigned SLOT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              port_reset_i,
  input  logic              busy_load_i,
  input  logic [SLOT_W-1:0] busy_slot_i,
  input  logic              clr_req_i,
  input  logic [SLOT_W-1:0] clr_slot_i,
  input  logic              ack_i,
  input  logic [7:0]        status_i,
  input  logic [7:0]        error_i,
  input  logic [7:0]        nsect_i,
  input  logic [7:0]        sector_i,
  input  logic [7:0]        lcyl_i,
  input  logic [7:0]        hcyl_i,
  output logic [15:0]       tfd_o,
  output logic [31:0]       sig_o,
  output logic              req_o,
  output logic              busy_valid_o,
  output logic [SLOT_W-1:0] busy_slot_o
);

  logic [15:0]       tfd_q, tfd_d;
  logic [31:0]       sig_q, sig_d;
  logic              sent_q, sent_d;
  logic              bv_q, bv_d;
  logic [SLOT_W-1:0] bs_q, bs_d;
  logic              accept, d2h_en, sent_en, busy_en;

  always_comb begin
    accept  = ack_i & ~sent_q & ~port_reset_i;
    d2h_en  = port_reset_i | accept;
    sent_en = port_reset_i | accept;
    busy_en = port_reset_i | busy_load_i | clr_req_i;
    if (port_reset_i) begin
      tfd_d  = TFD_RESET_VAL;
      sig_d  = SIG_RESET_VAL;
      sent_d = 1'b0;
    end else begin
      tfd_d  = {error_i, status_i};
      sig_d  = {hcyl_i, lcyl_i, sector_i, nsect_i};
      sent_d = 1'b1;
    end
    bv_d = bv_q;
    bs_d = bs_q;
    if (port_reset_i) begin
      bv_d = 1'b0;
      bs_d = '0;
    end else begin
      if (busy_load_i) begin
        bv_d = 1'b1;
        bs_d = busy_slot_i;
      end
      if (clr_req_i && (clr_slot_i == bs_d)) begin
        bv_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      tfd_q  <= TFD_RESET_VAL;
      sig_q  <= SIG_RESET_VAL;
      sent_q <= 1'b0;
      bv_q   <= 1'b0;
      bs_q   <= '0;
    end else begin
      if (d2h_en)  tfd_q  <= tfd_d;
      if (d2h_en)  sig_q  <= sig_d;
      if (sent_en) sent_q <= sent_d;
      if (busy_en) begin
        bv_q <= bv_d;
        bs_q <= bs_d;
      end
    end
  end

  assign tfd_o        = tfd_q;
  assign sig_o        = sig_q;
  assign req_o        = ~sent_q;
  assign busy_valid_o = bv_q;
  assign busy_slot_o  = bs_q;

  AST_PORT_RESET_VALUES: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    port_reset_i |=> (tfd_q == TFD_RESET_VAL && sig_q == SIG_RESET_VAL && !sent_q && !bv_q)); // R4

  AST_SENT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (sent_q && !port_reset_i) |=> sent_q); // R6

  AST_SIG_KEPT_WITHOUT_REQ: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (sent_q && !port_reset_i) |=> $stable(sig_q)); // R7

  AST_BUSY_LOADED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (busy_load_i && !clr_req_i && !port_reset_i) |=> (bv_q && bs_q == $past(busy_slot_i))); // R9

endmodule

// File: rtl/ahci_srst_seq.sv
module ahci_srst_seq
  import ahci_srst_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 32,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_n_i,
  input  logic                 comreset_i,
  input  logic                 h2d_valid_i,
  input  logic [7:0]           h2d_devctl_i,
  input  logic [SLOT_W-1:0]    h2d_slot_i,
  input  logic                 h2d_clr_busy_i,
  input  logic                 issue_valid_i,
  input  logic [NUM_SLOTS-1:0] issue_ci_i,
  input  logic [NUM_SLOTS-1:0] issue_sact_i,
  input  logic                 d2h_ack_i,
  input  logic [7:0]           d2h_status_i,
  input  logic [7:0]           d2h_error_i,
  input  logic [7:0]           d2h_nsect_i,
  input  logic [7:0]           d2h_sector_i,
  input  logic [7:0]           d2h_lcyl_i,
  input  logic [7:0]           d2h_hcyl_i,
  output logic                 port_in_reset_o,
  output logic [NUM_SLOTS-1:0] ci_o,
  output logic [NUM_SLOTS-1:0] sact_o,
  output logic [15:0]          tfd_o,
  output logic [31:0]          sig_o,
  output logic                 busy_valid_o,
  output logic [SLOT_W-1:0]    busy_slot_o,
  output logic                 init_d2h_req_o,
  output logic                 clr_pulse_o,
  output logic [SLOT_W-1:0]    clr_slot_o
);

  logic        rst_n;
  logic        srst;
  logic        port_reset;
  logic        srst_enter;
  logic        clr_req;
  logic        fis_run;
  port_state_e state;
  logic        unused_devctl;

  assign srst          = h2d_devctl_i[DEVCTL_SRST_BIT];
  assign unused_devctl = ^{h2d_devctl_i[7:DEVCTL_SRST_BIT+1], h2d_devctl_i[DEVCTL_SRST_BIT-1:0]};
  assign clr_req       = srst_enter & h2d_clr_busy_i;
  assign fis_run       = h2d_valid_i & (state == PS_RUN) & ~comreset_i;

  ahci_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .rst_sync_n_o(rst_n)
  );

  ahci_srst_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n),
    .fis_valid_i (h2d_valid_i),
    .srst_i      (srst),
    .comreset_i  (comreset_i),
    .state_o     (state),
    .port_reset_o(port_reset),
    .srst_enter_o(srst_enter)
  );

  ahci_ci_bitmap #(.NUM_SLOTS(NUM_SLOTS)) u_ci (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n),
    .port_reset_i (port_reset),
    .issue_valid_i(issue_valid_i),
    .issue_ci_i   (issue_ci_i),
    .issue_sact_i (issue_sact_i),
    .clr_req_i    (clr_req),
    .clr_slot_i   (h2d_slot_i),
    .ci_o         (ci_o),
    .sact_o       (sact_o),
    .clr_pulse_o  (clr_pulse_o),
    .clr_slot_o   (clr_slot_o)
  );

  ahci_port_regs #(.SLOT_W(SLOT_W)) u_regs (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n),
    .port_reset_i(port_reset),
    .busy_load_i (fis_run),
    .busy_slot_i (h2d_slot_i),
    .clr_req_i   (clr_req),
    .clr_slot_i  (h2d_slot_i),
    .ack_i       (d2h_ack_i),
    .status_i    (d2h_status_i),
    .error_i     (d2h_error_i),
    .nsect_i     (d2h_nsect_i),
    .sector_i    (d2h_sector_i),
    .lcyl_i      (d2h_lcyl_i),
    .hcyl_i      (d2h_hcyl_i),
    .tfd_o       (tfd_o),
    .sig_o       (sig_o),
    .req_o       (init_d2h_req_o),
    .busy_valid_o(busy_valid_o),
    .busy_slot_o (busy_slot_o)
  );

  assign port_in_reset_o = (state == PS_RESET);

  AST_PULSE_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_n)
    clr_pulse_o |-> $past(h2d_valid_i && h2d_clr_busy_i && srst && !comreset_i && state == PS_RUN)); // R2

  AST_COMRESET_WINS: assert property (@(posedge clk_i) disable iff (!rst_n)
    comreset_i |=> (!clr_pulse_o && init_d2h_req_o && ci_o == '0)); // R5

  AST_ACK_KEEPS_CI: assert property (@(posedge clk_i) disable iff (!rst_n)
    (d2h_ack_i && !comreset_i && !h2d_valid_i && !issue_valid_i) |=> $stable(ci_o)); // R6

  AST_REQ_AFTER_RESET_FIS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (h2d_valid_i && !srst && state == PS_RESET) |=> (init_d2h_req_o && !port_in_reset_o)); // R4

endmodule

// File: tb/sim_ahci_srst_seq.sv
module sim_ahci_srst_seq;

  logic        clk;
  logic        rst_n;
  logic        comreset;
  logic        h2d_valid;
  logic [7:0]  h2d_devctl;
  logic [4:0]  h2d_slot;
  logic        h2d_clr;
  logic        iss_valid;
  logic [31:0] iss_ci, iss_sact;
  logic        ack;
  logic [7:0]  st, er, ns, sc, lc, hc;

  logic        o_rst;
  logic [31:0] o_ci, o_sact, o_sig;
  logic [15:0] o_tfd;
  logic        o_bv, o_req, o_pulse;
  logic [4:0]  o_bs, o_pslot;

  logic        m_rst, m_sent, m_bv, m_pulse;
  logic [31:0] m_ci, m_sact, m_sig;
  logic [15:0] m_tfd;
  logic [4:0]  m_bs, m_pslot;

  int n_chk = 0;
  int n_fail = 0;

  ahci_srst_seq u0 (
    .clk_i(clk), .rst_n_i(rst_n), .comreset_i(comreset),
    .h2d_valid_i(h2d_valid), .h2d_devctl_i(h2d_devctl), .h2d_slot_i(h2d_slot),
    .h2d_clr_busy_i(h2d_clr), .issue_valid_i(iss_valid), .issue_ci_i(iss_ci),
    .issue_sact_i(iss_sact), .d2h_ack_i(ack), .d2h_status_i(st), .d2h_error_i(er),
    .d2h_nsect_i(ns), .d2h_sector_i(sc), .d2h_lcyl_i(lc), .d2h_hcyl_i(hc),
    .port_in_reset_o(o_rst), .ci_o(o_ci), .sact_o(o_sact), .tfd_o(o_tfd),
    .sig_o(o_sig), .busy_valid_o(o_bv), .busy_slot_o(o_bs),
    .init_d2h_req_o(o_req), .clr_pulse_o(o_pulse), .clr_slot_o(o_pslot)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic idle();
    comreset = 0; h2d_valid = 0; h2d_devctl = 8'h00; h2d_slot = 0; h2d_clr = 0;
    iss_valid = 0; iss_ci = 0; iss_sact = 0; ack = 0;
    st = 0; er = 0; ns = 0; sc = 0; lc = 0; hc = 0;
  endtask

  task automatic model_reset();
    m_rst = 0; m_sent = 0; m_bv = 0; m_bs = 0; m_pulse = 0;
    m_ci = 0; m_sact = 0; m_tfd = 16'h007F; m_sig = 32'hFFFF_FFFF;
  endtask

  task automatic model_step();
    logic srst;
    srst = h2d_devctl[2];
    if (comreset || (h2d_valid && m_rst && !srst)) begin
      model_reset();
    end else begin
      m_pulse = 0;
      if (iss_valid) begin
        m_ci = m_ci | iss_ci;
        m_sact = m_sact | iss_sact;
      end
      if (ack && !m_sent) begin
        m_sent = 1;
        m_sig = {hc, lc, sc, ns};
        m_tfd = {er, st};
      end
      if (h2d_valid && !m_rst) begin
        m_bv = 1; m_bs = h2d_slot;
        if (srst) begin
          m_rst = 1;
          if (h2d_clr) begin
            m_ci[h2d_slot] = 1'b0;
            m_pulse = 1; m_pslot = h2d_slot; m_bv = 0;
          end
        end
      end
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "state", {31'd0, o_rst}, {31'd0, m_rst});
    chk(tag, "ci", o_ci, m_ci);
    chk(tag, "sact", o_sact, m_sact);
    chk(tag, "tfd", {16'd0, o_tfd}, {16'd0, m_tfd});
    chk(tag, "sig", o_sig, m_sig);
    chk(tag, "busy_valid", {31'd0, o_bv}, {31'd0, m_bv});
    if (m_bv) chk(tag, "busy_slot", {27'd0, o_bs}, {27'd0, m_bs});
    chk(tag, "req", {31'd0, o_req}, {31'd0, !m_sent});
    chk(tag, "pulse", {31'd0, o_pulse}, {31'd0, m_pulse});
    if (m_pulse) chk(tag, "pulse_slot", {27'd0, o_pslot}, {27'd0, m_pslot});
  endtask

  task automatic step(input string tag);
    model_step();
    @(negedge clk);
    check_all(tag);
    idle();
  endtask

  task automatic fis(input logic srst, input logic [4:0] slot, input logic clr);
    h2d_valid = 1; h2d_devctl = srst ? 8'h04 : 8'h08; h2d_slot = slot; h2d_clr = clr;
  endtask

  task automatic give_ack(input logic [7:0] seed);
    ack = 1; st = seed ^ 8'h50; er = seed ^ 8'h01; ns = seed;
    sc = seed + 8'd1; lc = seed + 8'd2; hc = seed + 8'd3;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    idle();
    model_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check_all("R10");
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_all("R10");

    iss_valid = 1; iss_ci = 32'hFFFF_FFFF; iss_sact = 32'h0000_00F0;
    step("R8");
    give_ack(8'h21);
    step("R6");
    give_ack(8'h77);
    step("R7");

    for (int s = 0; s < 32; s++) begin
      for (int f = 0; f < 2; f++) begin
        iss_valid = 1; iss_ci = 32'hFFFF_FFFF; iss_sact = 32'h1 << s;
        step("R8");
        fis(1'b1, 5'(s), f[0]);
        step(f ? "R2" : "R1");
        fis(1'b1, 5'((s + 1) % 32), 1'b1);
        step("R3");
        if (s % 2 == 1) comreset = 1;
        else fis(1'b0, 5'(s), 1'b0);
        step(s % 2 == 1 ? "R5" : "R4");
        give_ack(8'(s * 7 + f));
        step("R7");
        fis(1'b0, 5'(31 - s), 1'b0);
        step("R9");
      end
    end

    iss_valid = 1; iss_ci = 32'h0000_0F0F;
    step("R8");
    comreset = 1; fis(1'b1, 5'd3, 1'b1);
    step("R5");
    iss_valid = 1; iss_ci = 32'hA5A5_0001;
    fis(1'b1, 5'd0, 1'b1);
    step("R8");
    fis(1'b0, 5'd4, 1'b0); give_ack(8'h99);
    step("R6");
    iss_valid = 1; iss_ci = 32'h0000_0010; iss_sact = 32'h0000_0010;
    fis(1'b1, 5'd4, 1'b1);
    step("R8");
    fis(1'b0, 5'd4, 1'b0);
    step("R4");
    give_ack(8'h3C);
    step("R7");
    iss_valid = 1; iss_ci = 32'h8000_0001;
    step("R8");
    fis(1'b1, 5'd31, 1'b0);
    step("R1");

    rst_n = 0;
    #1;
    model_reset();
    check_all("R10");
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_all("R10");

    finish_run();
  end

endmodule